// File: doc/BRIEF.md
# APS K-Byte Persistence Monitor

This block watches the two automatic protection switching bytes of a received line overhead, once per frame. Each frame, the framer presents the K1 and K2 bytes together with a one-cycle valid strobe. A new value is taken only after it has arrived unchanged in a run of N consecutive frames, where N is programmable. Accepted values are held and presented on the outputs.

The 13-bit switching field (all of K1 plus the upper five bits of K2) and the 3-bit line-status field (K2 bits 2:0) are filtered separately. Each has its own candidate, run counter and accepted value. Line AIS and line RDI are decoded from the accepted line-status field.

Every change of an accepted field or flag sets a sticky event bit. A write-one-to-clear access clears the sticky bits. Unmasked sticky bits drive a single interrupt line. Software that prefers polling reads the sticky bits and ignores the interrupt.

Top module: `aps_kbyte_monitor`

## Requirements
- R1: While reset is high and on the cycle after it, `aps_val`, `k2_low`, `line_ais`, `line_rdi`, `evt_sticky` and `irq` are all zero.
- R2: `aps_val` equals {K1[7:0], K2[7:3]}, with K1 in bits 12:5. A new field value appears on it in the cycle after the strobe that completes N identical consecutive strobes, and not before.
- R3: A strobe whose field differs from the current candidate restarts that field's run at one, so an interrupted run is not accepted.
- R4: `k2_low` is filtered on its own run. A change only in K2[2:0] leaves `aps_val` untouched, and a change only in the switching field leaves `k2_low` untouched.
- R5: `line_ais` is high exactly when the accepted `k2_low` is 3'b111, and `line_rdi` exactly when it is 3'b110.
- R6: `evt_sticky` bit 0 is set when `aps_val` changes, bit 1 when `k2_low` changes, bit 2 when `line_ais` changes and bit 3 when `line_rdi` changes. Each bit sets in the same cycle its output changes, and stays set.
- R7: With `clr_we` high, each 1 in `clr_bits` clears the matching sticky bit at the next edge. A bit set and cleared in the same cycle ends set.
- R8: `irq` is the OR of the sticky bits whose `irq_mask` bit is 0. A mask bit of 1 blocks its event from the interrupt but not from the sticky register.
- R9: `persist_n` = 1 accepts a new value on its first strobe. `persist_n` = 0 behaves as 1. `persist_n` = 15 needs 15 strobes.
- R10: Without `frame_vld`, the byte inputs are ignored: the run state, the accepted values and the event bits set by accepts do not change.
- R11: A completed run of the value already accepted sets no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One strobe per frame, qualifies the byte inputs |
| k1_in | input | 8 | Received K1 byte |
| k2_in | input | 8 | Received K2 byte |
| persist_n | input | 4 | Consecutive-frame count required for acceptance |
| irq_mask | input | 4 | 1 blocks the matching event from the interrupt |
| clr_we | input | 1 | Clear strobe for the sticky register |
| clr_bits | input | 4 | Write-one-to-clear pattern |
| aps_val | output | 13 | Accepted {K1, K2[7:3]} |
| k2_low | output | 3 | Accepted K2[2:0] |
| line_ais | output | 1 | Line AIS status |
| line_rdi | output | 1 | Line RDI status |
| evt_sticky | output | 4 | Sticky change events: {RDI, AIS, K2 low, APS} |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the monitor with its default widths: 8-bit bytes and a 4-bit persistence count. This puts the full programmable range within reach, including the N = 0 clamp and the N = 15 boundary, where 14 strobes must not be enough. The random phase draws the bytes from a small value set and changes N during the run. This makes interrupted runs, repeats of the accepted value and AIS/RDI transitions frequent. Clears and masks are also random, so set-versus-clear collisions occur.

// File: rtl/kmon_pkg.sv
package kmon_pkg;
    localparam int KB_W   = 8;
    localparam int LOW_W  = 3;
    localparam int APS_W  = 2 * KB_W - LOW_W;
    localparam int CNT_W  = 4;
    localparam int EVT_N  = 4;

    typedef enum int unsigned {
        EV_APS = 0,
        EV_LOW = 1,
        EV_AIS = 2,
        EV_RDI = 3
    } evt_idx_e;

    localparam logic [LOW_W-1:0] CODE_AIS = 3'b111;
    localparam logic [LOW_W-1:0] CODE_RDI = 3'b110;

    typedef struct packed {
        logic [LOW_W-1:0] low;
        logic [APS_W-1:0] aps;
    } kfields_t;

    function automatic kfields_t split_k(input logic [KB_W-1:0] k1, input logic [KB_W-1:0] k2);
        kfields_t f;
        f.aps = {k1, k2[KB_W-1:LOW_W]};
        f.low = k2[LOW_W-1:0];
        return f;
    endfunction

    function automatic logic is_ais(input logic [LOW_W-1:0] v);
        return v == CODE_AIS;
    endfunction

    function automatic logic is_rdi(input logic [LOW_W-1:0] v);
        return v == CODE_RDI;
    endfunction
endpackage

// File: rtl/kmon_persist.sv
module kmon_persist #(
    parameter int W     = 13,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [W-1:0]     din,
    input  logic [CNT_W-1:0] n_req,
    output logic [W-1:0]     acc_q,
    output logic [W-1:0]     acc_nxt,
    output logic             upd
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    logic [W-1:0]     cand_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nxt;
    logic [CNT_W-1:0] n_eff;

    always_comb begin
        n_eff = (n_req == '0) ? RUN_ONE : n_req;
        if (din == cand_q)
            run_nxt = (run_q == RUN_MAX) ? run_q : run_q + RUN_ONE;
        else
            run_nxt = RUN_ONE;
        upd     = vld && (run_nxt >= n_eff) && (din != acc_q);
        acc_nxt = upd ? din : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
            run_q  <= '0;
            acc_q  <= '0;
        end else if (vld) begin
            cand_q <= din;
            run_q  <= run_nxt;
            acc_q  <= acc_nxt;
        end
    end
endmodule

// File: rtl/kmon_events.sv
module kmon_events #(
    parameter int EVT_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] set_i,
    input  logic             clr_we,
    input  logic [EVT_N-1:0] clr_bits,
    input  logic [EVT_N-1:0] mask,
    output logic [EVT_N-1:0] sticky,
    output logic             irq
);
    logic [EVT_N-1:0] live;

    for (genvar i = 0; i < EVT_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sticky[i] <= 1'b0;
            else if (set_i[i])
                sticky[i] <= 1'b1;
            else if (clr_we && clr_bits[i])
                sticky[i] <= 1'b0;
        end
        assign live[i] = sticky[i] & ~mask[i];
    end

    assign irq = |live;
endmodule

// File: rtl/aps_kbyte_monitor.sv
module aps_kbyte_monitor
    import kmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_vld,
    input  logic [KB_W-1:0]  k1_in,
    input  logic [KB_W-1:0]  k2_in,
    input  logic [CNT_W-1:0] persist_n,
    input  logic [EVT_N-1:0] irq_mask,
    input  logic             clr_we,
    input  logic [EVT_N-1:0] clr_bits,
    output logic [APS_W-1:0] aps_val,
    output logic [LOW_W-1:0] k2_low,
    output logic             line_ais,
    output logic             line_rdi,
    output logic [EVT_N-1:0] evt_sticky,
    output logic             irq
);
    kfields_t         in_f;
    logic [APS_W-1:0] aps_nxt;
    logic [LOW_W-1:0] low_nxt;
    logic             aps_upd;
    logic             low_upd;
    logic [EVT_N-1:0] evt_set;

    assign in_f = split_k(k1_in, k2_in);

    kmon_persist #(.W(APS_W), .CNT_W(CNT_W)) u_aps_flt (
        .clk     (clk),
        .rst     (rst),
        .vld     (frame_vld),
        .din     (in_f.aps),
        .n_req   (persist_n),
        .acc_q   (aps_val),
        .acc_nxt (aps_nxt),
        .upd     (aps_upd)
    );

    kmon_persist #(.W(LOW_W), .CNT_W(CNT_W)) u_low_flt (
        .clk     (clk),
        .rst     (rst),
        .vld     (frame_vld),
        .din     (in_f.low),
        .n_req   (persist_n),
        .acc_q   (k2_low),
        .acc_nxt (low_nxt),
        .upd     (low_upd)
    );

    assign line_ais = is_ais(k2_low);
    assign line_rdi = is_rdi(k2_low);

    always_comb begin
        evt_set         = '0;
        evt_set[EV_APS] = aps_upd;
        evt_set[EV_LOW] = low_upd;
        evt_set[EV_AIS] = low_upd && (is_ais(low_nxt) != line_ais);
        evt_set[EV_RDI] = low_upd && (is_rdi(low_nxt) != line_rdi);
    end

    kmon_events #(.EVT_N(EVT_N)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt_set),
        .clr_we   (clr_we),
        .clr_bits (clr_bits),
        .mask     (irq_mask),
        .sticky   (evt_sticky),
        .irq      (irq)
    );
endmodule

// File: rtl/kmon_checker.sv
module kmon_checker
    import kmon_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frame_vld,
    input logic [KB_W-1:0]  k1_in,
    input logic [KB_W-1:0]  k2_in,
    input logic [CNT_W-1:0] persist_n,
    input logic [EVT_N-1:0] irq_mask,
    input logic             clr_we,
    input logic [EVT_N-1:0] clr_bits,
    input logic [APS_W-1:0] aps_val,
    input logic [LOW_W-1:0] k2_low,
    input logic             line_ais,
    input logic             line_rdi,
    input logic [EVT_N-1:0] evt_sticky,
    input logic             irq
);
    a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> ($stable(aps_val) && $stable(k2_low)));

    a_r9_single_frame_accept: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && persist_n <= 4'd1 && {k1_in, k2_in[7:3]} != aps_val)
        |=> (aps_val == $past({k1_in, k2_in[7:3]})));

    a_r6_aps_change_event: assert property (@(posedge clk) disable iff (rst)
        !$stable(aps_val) |-> evt_sticky[0]);

    a_r6_ais_change_event: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_ais) |-> evt_sticky[2]);

    a_r5_status_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(line_ais && line_rdi));

    a_r7_sticky_retained: assert property (@(posedge clk) disable iff (rst)
        (evt_sticky[1] && !(clr_we && clr_bits[1])) |=> evt_sticky[1]);

    a_r8_quiet_without_events: assert property (@(posedge clk) disable iff (rst)
        (evt_sticky == '0) |-> !irq);
endmodule

bind aps_kbyte_monitor kmon_checker u_kmon_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_vld  (frame_vld),
    .k1_in      (k1_in),
    .k2_in      (k2_in),
    .persist_n  (persist_n),
    .irq_mask   (irq_mask),
    .clr_we     (clr_we),
    .clr_bits   (clr_bits),
    .aps_val    (aps_val),
    .k2_low     (k2_low),
    .line_ais   (line_ais),
    .line_rdi   (line_rdi),
    .evt_sticky (evt_sticky),
    .irq        (irq)
);

// File: tb/aps_kbyte_monitor_tb_top.sv
module aps_kbyte_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       frame_vld;
    logic [7:0] k1_in, k2_in;
    logic [3:0] persist_n, irq_mask, clr_bits;
    logic       clr_we;
    logic [12:0] aps_val;
    logic [2:0]  k2_low;
    logic        line_ais, line_rdi, irq;
    logic [3:0]  evt_sticky;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aps_kbyte_monitor dut_i (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .k1_in(k1_in), .k2_in(k2_in),
        .persist_n(persist_n), .irq_mask(irq_mask), .clr_we(clr_we), .clr_bits(clr_bits),
        .aps_val(aps_val), .k2_low(k2_low), .line_ais(line_ais), .line_rdi(line_rdi),
        .evt_sticky(evt_sticky), .irq(irq)
    );

    // behavioural reference
    int m_cand_a, m_cnt_a, m_acc_a, m_cand_b, m_cnt_b, m_acc_b, m_evt, m_n, m_set, m_ia, m_ib;
    int m_oais, m_ordi;

    always @(posedge clk) begin
        if (rst) begin
            m_cand_a = 0; m_cnt_a = 0; m_acc_a = 0;
            m_cand_b = 0; m_cnt_b = 0; m_acc_b = 0; m_evt = 0;
        end else begin
            m_n = (persist_n == 0) ? 1 : int'(persist_n);
            m_set = 0;
            if (frame_vld) begin
                m_ia = int'({k1_in, k2_in[7:3]});
                m_ib = int'(k2_in[2:0]);
                if (m_ia == m_cand_a) m_cnt_a = (m_cnt_a < 15) ? m_cnt_a + 1 : 15;
                else begin m_cand_a = m_ia; m_cnt_a = 1; end
                if (m_cnt_a >= m_n && m_ia != m_acc_a) begin m_acc_a = m_ia; m_set |= 1; end
                if (m_ib == m_cand_b) m_cnt_b = (m_cnt_b < 15) ? m_cnt_b + 1 : 15;
                else begin m_cand_b = m_ib; m_cnt_b = 1; end
                if (m_cnt_b >= m_n && m_ib != m_acc_b) begin
                    m_oais = (m_acc_b == 7) ? 1 : 0;
                    m_ordi = (m_acc_b == 6) ? 1 : 0;
                    m_acc_b = m_ib;
                    m_set |= 2;
                    if (((m_acc_b == 7) ? 1 : 0) != m_oais) m_set |= 4;
                    if (((m_acc_b == 6) ? 1 : 0) != m_ordi) m_set |= 8;
                end
            end
            m_evt = (m_evt & ~(clr_we ? int'(clr_bits) : 0)) | m_set;
        end
    end

    function automatic int exp_irq();
        return ((m_evt & ~int'(irq_mask) & 15) != 0) ? 1 : 0;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (int'(aps_val) != m_acc_a || int'(k2_low) != m_acc_b || int'(evt_sticky) != m_evt ||
                int'(line_ais) != ((m_acc_b == 7) ? 1 : 0) || int'(line_rdi) != ((m_acc_b == 6) ? 1 : 0) ||
                int'(irq) != exp_irq()) begin
                bad++;
                $display("FAIL model R2 R4 R5 R6 R8: aps=%h/%h low=%0d/%0d evt=%h/%h irq=%0d/%0d",
                         aps_val, m_acc_a, k2_low, m_acc_b, evt_sticky, m_evt, irq, exp_irq());
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk); #3;
    endtask

    task automatic send(input logic [7:0] a, input logic [7:0] b);
        frame_vld = 1'b1; k1_in = a; k2_in = b;
        tick();
        frame_vld = 1'b0;
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_bits = 4'hF; tick(); clr_we = 1'b0; clr_bits = 4'h0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_vld = 1'b0; k1_in = 8'h00; k2_in = 8'h00;
        persist_n = 4'd3; irq_mask = 4'h0; clr_we = 1'b0; clr_bits = 4'h0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk({aps_val, k2_low, line_ais, line_rdi, evt_sticky, irq} == '0, "R1 reset",
            int'({aps_val, k2_low, evt_sticky, irq}), 0);

        // N = 3 acceptance, value 0xA5 / 0x48 -> field {A5, 01001}
        send(8'hA5, 8'h48); send(8'hA5, 8'h48);
        chk(aps_val == 13'h0, "R2 not before N", int'(aps_val), 0);
        send(8'hA5, 8'h48);
        chk(aps_val == {8'hA5, 5'b01001}, "R2 accepted at N", int'(aps_val), int'({8'hA5, 5'b01001}));
        chk(evt_sticky == 4'b0001, "R6 aps event", int'(evt_sticky), 1);
        chk(irq == 1'b1, "R8 irq on event", int'(irq), 1);
        chk(k2_low == 3'd0, "R4 low untouched", int'(k2_low), 0);

        // interrupted run
        clear_all();
        send(8'h3C, 8'h48); send(8'h3C, 8'h48); send(8'h11, 8'h48);
        send(8'h3C, 8'h48); send(8'h3C, 8'h48);
        chk(aps_val == {8'hA5, 5'b01001}, "R3 interrupted run", int'(aps_val), int'({8'hA5, 5'b01001}));
        send(8'h3C, 8'h48);
        chk(aps_val == {8'h3C, 5'b01001}, "R3 accepted after restart", int'(aps_val), int'({8'h3C, 5'b01001}));

        // AIS on low field only
        clear_all();
        repeat (3) send(8'h3C, 8'h4F);
        chk(k2_low == 3'b111, "R4 low accepted", int'(k2_low), 7);
        chk(aps_val == {8'h3C, 5'b01001}, "R4 aps kept", int'(aps_val), int'({8'h3C, 5'b01001}));
        chk(line_ais && !line_rdi, "R5 ais", int'({line_ais, line_rdi}), 2);
        chk(evt_sticky == 4'b0110, "R6 low+ais events", int'(evt_sticky), 6);

        // RDI
        repeat (3) send(8'h3C, 8'h4E);
        chk(!line_ais && line_rdi, "R5 rdi", int'({line_ais, line_rdi}), 1);
        chk(evt_sticky == 4'b1110, "R6 rdi event", int'(evt_sticky), 14);

        // masking
        irq_mask = 4'hF; #1;
        chk(irq == 1'b0, "R8 masked", int'(irq), 0);
        irq_mask = 4'b1011; #1;
        chk(irq == 1'b1, "R8 partial mask", int'(irq), 1);
        irq_mask = 4'h0;

        // W1C
        clr_we = 1'b1; clr_bits = 4'b0100; tick(); clr_we = 1'b0;
        chk(evt_sticky == 4'b1010, "R7 partial clear", int'(evt_sticky), 10);
        clear_all();
        chk(evt_sticky == 4'b0000, "R7 full clear", int'(evt_sticky), 0);

        // N = 1 and set-wins-over-clear
        persist_n = 4'd1;
        clr_we = 1'b1; clr_bits = 4'b0001;
        send(8'h77, 8'h4E);
        clr_we = 1'b0;
        chk(aps_val == {8'h77, 5'b01001}, "R9 N=1 immediate", int'(aps_val), int'({8'h77, 5'b01001}));
        chk(evt_sticky[0] == 1'b1, "R7 set wins", int'(evt_sticky), 1);
        persist_n = 4'd0;
        send(8'h12, 8'h4E);
        chk(aps_val == {8'h12, 5'b01001}, "R9 N=0 as 1", int'(aps_val), int'({8'h12, 5'b01001}));

        // inputs without strobe ignored
        clear_all();
        k1_in = 8'hEE; k2_in = 8'h07;
        repeat (4) tick();
        chk(aps_val == {8'h12, 5'b01001} && k2_low == 3'b110 && evt_sticky == 0,
            "R10 no strobe", int'(evt_sticky), 0);

        // repeat of accepted value
        persist_n = 4'd2;
        repeat (3) send(8'h12, 8'h4E);
        chk(evt_sticky == 4'b0000, "R11 repeat no event", int'(evt_sticky), 0);

        // N = 15 boundary
        persist_n = 4'd15;
        repeat (14) send(8'hC3, 8'h4E);
        chk(aps_val == {8'h12, 5'b01001}, "R9 N=15 short", int'(aps_val), int'({8'h12, 5'b01001}));
        send(8'hC3, 8'h4E);
        chk(aps_val == {8'hC3, 5'b01001}, "R9 N=15 accepted", int'(aps_val), int'({8'hC3, 5'b01001}));

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ((i % 300) == 0) persist_n = 4'($urandom_range(0, 4));
            frame_vld = ($urandom_range(0, 3) != 0);
            k1_in = ($urandom_range(0, 1) != 0) ? 8'h5A : 8'h00;
            case ($urandom_range(0, 3))
                0: k2_in = 8'hF8 | 8'd7;
                1: k2_in = 8'hF8 | 8'd6;
                2: k2_in = 8'h08 | 8'd2;
                default: k2_in = 8'hF8;
            endcase
            clr_we = ($urandom_range(0, 7) == 0);
            clr_bits = 4'($urandom_range(0, 15));
            irq_mask = 4'($urandom_range(0, 15));
            tick();
        end
        frame_vld = 1'b0; clr_we = 1'b0;
        tick();

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule